// File: doc/BRIEF.md
# Redundant Reference Clock Failover Monitor

This block watches two reference clocks and decides which one a downstream clock multiplexer should pass. A fast local sampling clock oversamples both references and a feedback clock. The feedback clock serves as the time base for judging whether a reference has stopped. A reference that holds one level, high or low, across a full feedback period is marked failed. Its failure flag then stays set until the alarm reset is pulled low.

The selection register normally follows a static preferred-clock pin. When the reference in use fails and the other one is still healthy, the selection moves to the healthy one on its own. A failure on the idle reference only raises that reference's flag. A manual override turns the automatic move off, and the selection then simply tracks the preferred pin. Pulling the active-low alarm reset low clears both flags, restarts monitoring and puts the selection back on the preferred pin. The alarm reset acts synchronously in the sampling domain and is also the block's reset.

Top module: `refclk_failover`

## Requirements
- R1: A reference flag sets once the synchronized reference has shown no transition across two rising edges of the synchronized feedback clock. A reference whose level changes at intervals shorter than one feedback period never gets flagged.
- R2: A set failure flag stays high, even if the reference starts toggling again, for as long as the alarm reset stays high.
- R3: With override low, if the flag of the selected reference is set and the other flag is clear, the selection moves to the other reference one sampling cycle later.
- R4: With override low, the selection never changes while the selected reference's flag is clear. This holds when the idle reference fails.
- R5: With override low and both flags set, the selection holds its value.
- R6: While override is high, the selection takes the value the preferred-clock pin had one sampling cycle earlier, whatever the flags say.
- R7: While alarm reset is low, on each sampling edge both flags clear and the selection is loaded from the preferred-clock pin.
- R8: Encoding: a preferred-clock pin of 0 picks reference 0 and 1 picks reference 1. `sel_now` is 0 when reference 0 is in use and 1 when reference 1 is in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_smp | input | 1 | Fast sampling clock |
| ref0_in | input | 1 | Monitored reference clock 0 |
| ref1_in | input | 1 | Monitored reference clock 1 |
| fb_in | input | 1 | Feedback clock, the time base for failure detection |
| pref_sel | input | 1 | Static preferred reference (0 = ref 0, 1 = ref 1) |
| man_ovr | input | 1 | Manual override; high disables automatic switching |
| alarm_rst_n | input | 1 | Active-low alarm reset, synchronous to clk_smp |
| bad0 | output | 1 | Sticky failure flag of reference 0 |
| bad1 | output | 1 | Sticky failure flag of reference 1 |
| sel_now | output | 1 | Reference currently in use |

## Verification
The hardest case to reach is the edge of detection: a reference whose gap between edges is only slightly shorter than a feedback period must not be flagged. The bench stretches one half period of reference 0 to 36 ns against a 40 ns feedback period. Every stimulus edge is placed off the sampling edges, so each gap lands on a known number of sampling cycles. A sweep then covers every combination of failed input, stuck level and preferred pin, and checks the flags and the switching outcome of each. Dedicated runs cover both references failing and a failure under override.

// File: rtl/refclk_failover.sv
module refclk_failover #(
  parameter int SYNC_STAGES = 2,
  parameter int STALL_EDGES = 2
) (
  input  logic clk_smp,
  input  logic ref0_in,
  input  logic ref1_in,
  input  logic fb_in,
  input  logic pref_sel,
  input  logic man_ovr,
  input  logic alarm_rst_n,
  output logic bad0,
  output logic bad1,
  output logic sel_now
);
  localparam int CW = $clog2(STALL_EDGES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(STALL_EDGES);

  logic [SYNC_STAGES-1:0] sync0, sync1, syncf;
  logic [2:0] last;
  logic [CW-1:0] stall [2];
  logic [1:0] bad;

  wire [1:0] ref_s   = {sync1[SYNC_STAGES-1], sync0[SYNC_STAGES-1]};
  wire       fb_s    = syncf[SYNC_STAGES-1];
  wire       fb_rise = fb_s & ~last[2];
  wire [1:0] ref_tog = ref_s ^ last[1:0];
  wire       cur_bad = sel_now ? bad[1] : bad[0];
  wire       alt_bad = sel_now ? bad[0] : bad[1];

  always_ff @(posedge clk_smp) begin
    if (!alarm_rst_n) begin
      sync0 <= '0;
      sync1 <= '0;
      syncf <= '0;
      last  <= '0;
    end else begin
      sync0 <= {sync0[SYNC_STAGES-2:0], ref0_in};
      sync1 <= {sync1[SYNC_STAGES-2:0], ref1_in};
      syncf <= {syncf[SYNC_STAGES-2:0], fb_in};
      last  <= {fb_s, ref_s};
    end
  end

  always_ff @(posedge clk_smp) begin
    for (int i = 0; i < 2; i++) begin
      if (!alarm_rst_n) begin
        stall[i] <= '0;
        bad[i]   <= 1'b0;
      end else begin
        if (ref_tog[i])
          stall[i] <= '0;
        else if (fb_rise && stall[i] != LIMIT)
          stall[i] <= stall[i] + 1'b1;
        if (stall[i] == LIMIT)
          bad[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_smp) begin
    if (!alarm_rst_n || man_ovr)
      sel_now <= pref_sel;
    else if (cur_bad && !alt_bad)
      sel_now <= ~sel_now;
  end

  assign bad0 = bad[0];
  assign bad1 = bad[1];
endmodule

// File: rtl/refclk_failover_chk.sv
module refclk_failover_chk (
  input logic clk_smp,
  input logic alarm_rst_n,
  input logic pref_sel,
  input logic man_ovr,
  input logic bad0,
  input logic bad1,
  input logic sel_now
);
  wire sel_bad   = sel_now ? bad1 : bad0;
  wire other_bad = sel_now ? bad0 : bad1;

  AST_FLAG0_STICKY: assert property (@(posedge clk_smp) disable iff (!alarm_rst_n)
    bad0 |=> bad0); // R2
  AST_FLAG1_STICKY: assert property (@(posedge clk_smp) disable iff (!alarm_rst_n)
    bad1 |=> bad1); // R2
  AST_SWITCH_AWAY: assert property (@(posedge clk_smp) disable iff (!alarm_rst_n)
    (!man_ovr && sel_bad && !other_bad) |=> (sel_now != $past(sel_now))); // R3
  AST_IDLE_FAIL_NO_MOVE: assert property (@(posedge clk_smp) disable iff (!alarm_rst_n)
    (!man_ovr && !sel_bad) |=> $stable(sel_now)); // R4
  AST_BOTH_BAD_HOLD: assert property (@(posedge clk_smp) disable iff (!alarm_rst_n)
    (!man_ovr && bad0 && bad1) |=> $stable(sel_now)); // R5
  AST_OVERRIDE_FOLLOW: assert property (@(posedge clk_smp) disable iff (!alarm_rst_n)
    man_ovr |=> (sel_now == $past(pref_sel))); // R6
endmodule

bind refclk_failover refclk_failover_chk u_chk (
  .clk_smp(clk_smp),
  .alarm_rst_n(alarm_rst_n),
  .pref_sel(pref_sel),
  .man_ovr(man_ovr),
  .bad0(bad0),
  .bad1(bad1),
  .sel_now(sel_now)
);

// File: tb/refclk_failover_tb.sv
`timescale 1ns/1ps
module refclk_failover_tb;
  logic clk = 1'b0;
  logic r0, r1, fb;
  logic pref = 1'b0, ovr = 1'b0, arst_n = 1'b0;
  logic lvl0 = 1'b0, lvl1 = 1'b0;
  bit run0 = 1'b1, run1 = 1'b1, done = 1'b0;
  int hp0 = 20;
  int vec = 0, miss = 0;
  logic bad0, bad1, sel_now;

  refclk_failover u_dut (
    .clk_smp(clk), .ref0_in(r0), .ref1_in(r1), .fb_in(fb),
    .pref_sel(pref), .man_ovr(ovr), .alarm_rst_n(arst_n),
    .bad0(bad0), .bad1(bad1), .sel_now(sel_now)
  );

  // 250 MHz: rising edges at 2 + 4k ns; stimulus edges never land there
  always #2 clk = ~clk;
  initial begin r0 = 1'b0; #1; forever begin #(hp0); r0 = run0 ? ~r0 : lvl0; end end
  initial begin r1 = 1'b0; #1; forever begin #24;    r1 = run1 ? ~r1 : lvl1; end end
  initial begin fb = 1'b0; #3; forever begin #20;    fb = ~fb; end end

  task automatic chk(input string req, input logic act, input logic exp);
    vec++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic alarm(input logic p);
    pref = p;
    arst_n = 1'b0;
    cyc(3);
    chk("R7", bad0, 1'b0);
    chk("R7", bad1, 1'b0);
    chk("R8", sel_now, p);
    arst_n = 1'b1;
  endtask

  initial begin
    cyc(10);
    chk("R7", bad0, 1'b0);
    chk("R7", bad1, 1'b0);
    chk("R8", sel_now, 1'b0);
    arst_n = 1'b1;
    cyc(60);
    chk("R1", bad0, 1'b0);
    chk("R1", bad1, 1'b0);

    // stretched half period, still shorter than one feedback period
    hp0 = 36;
    #80;
    hp0 = 20;
    cyc(60);
    chk("R1", bad0, 1'b0);

    // sweep: failed input x stuck level x preferred pin
    for (int k = 0; k < 2; k++)
      for (int l = 0; l < 2; l++)
        for (int p = 0; p < 2; p++) begin
          alarm(p[0]);
          cyc(60);
          chk("R1", bad0 | bad1, 1'b0);
          if (k == 0) begin lvl0 = l[0]; run0 = 1'b0; end
          else        begin lvl1 = l[0]; run1 = 1'b0; end
          cyc(50);
          chk("R1", k == 0 ? bad0 : bad1, 1'b1);
          chk("R1", k == 0 ? bad1 : bad0, 1'b0);
          if (k == p) chk("R3", sel_now, ~p[0]);
          else        chk("R4", sel_now, p[0]);
          run0 = 1'b1; run1 = 1'b1;
          cyc(60);
          chk("R2", k == 0 ? bad0 : bad1, 1'b1);
        end

    // both fail: ref1 selected fails first, then ref0
    alarm(1'b1);
    cyc(60);
    lvl1 = 1'b1; run1 = 1'b0;
    cyc(50);
    chk("R3", sel_now, 1'b0);
    lvl0 = 1'b0; run0 = 1'b0;
    cyc(50);
    chk("R1", bad0, 1'b1);
    chk("R5", sel_now, 1'b0);
    cyc(100);
    chk("R5", sel_now, 1'b0);
    run0 = 1'b1; run1 = 1'b1;

    // override during a failure
    alarm(1'b0);
    cyc(60);
    ovr = 1'b1;
    lvl0 = 1'b1; run0 = 1'b0;
    cyc(50);
    chk("R1", bad0, 1'b1);
    chk("R6", sel_now, 1'b0);
    pref = 1'b1;
    cyc(2);
    chk("R6", sel_now, 1'b1);
    pref = 1'b0;
    cyc(2);
    chk("R6", sel_now, 1'b0);
    // override released: failed selected ref with healthy partner moves away
    ovr = 1'b0;
    cyc(3);
    chk("R3", sel_now, 1'b1);
    run0 = 1'b1;

    // realignment to the pin after reset
    alarm(1'b0);
    cyc(40);
    chk("R2", bad0, 1'b0);
    chk("R8", sel_now, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      vec++;
      miss++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
      $finish;
    end
  end
endmodule